// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor that completes one instruction per clock. It has a program counter, a register file of thirty-two 32-bit words, an ALU, an immediate sign extender, a branch-target adder and the steering multiplexers that choose the destination register, the second ALU operand and the writeback source. It runs an eight-instruction integer subset: five register-to-register ALU operations, a word load, a word store and a branch-if-equal. The instruction store and the data store are separate word-wide arrays held inside the top module.

While reset is high, a load port fills either store one word per clock. Once reset falls, the instruction store is read-only and the core fetches from address 0. A third, combinational register-file read port lets the surrounding logic observe any register. Every data-store write the core makes also appears on the output pins in the cycle it happens.

Top module: `sc_core_top`

## Requirements
- R1: While `rst` is high, each rising edge sets the PC to 0 and clears every register. Right after reset the PC reads 0 and every register reads 0.
- R2: When no branch is taken, each rising edge with `rst` low advances the PC by 4.
- R3: A branch (opcode 000100, fields rs[25:21], rt[20:16], imm[15:0]) compares registers rs and rt. If they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2, so a negative immediate branches backwards. Otherwise the next PC is PC+4.
- R4: An R-type word (opcode 000000, rs[25:21], rt[20:16], rd[15:11], shamt[10:6] = 0, func[5:0]) writes register rd with the result of rs op rt. The func codes are add 100000, sub 100010, and 100100, or 100101, and slt 101010, where slt is a signed compare that gives 1 or 0.
- R5: A load (opcode 100011) writes register rt with the data word at byte address rs + sign-extended imm. The word index is bits [DA_W+1:2] of that address.
- R6: A store (opcode 101011) writes register rt to the data word at byte address rs + sign-extended imm and writes no register. `dm_we_o`, `dm_addr_o` and `dm_wdata_o` show the write in that cycle.
- R7: Register 0 always reads 0, and writes to it are discarded.
- R8: An unrecognised opcode, an unrecognised func, or an R-type word with non-zero shamt writes no register and no data word, and the PC advances by 4.
- R9: The load port writes the instruction store (`load_sel`=0) or the data store (`load_sel`=1) only while `rst` is high. It has no effect while the core runs.
- R10: `dbg_val` shows the register selected by `dbg_sel` combinationally, including a value written at the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| load_en | input | 1 | Load-port write strobe |
| load_sel | input | 1 | Load-port target: 0 instruction store, 1 data store |
| load_addr | input | LD_W (6) | Word index for the load-port write |
| load_data | input | 32 | Word to store through the load port |
| dbg_sel | input | 5 | Register number for the observation read port |
| dbg_val | output | 32 | Value of register `dbg_sel` |
| pc_o | output | 32 | Current program counter (byte address) |
| dm_we_o | output | 1 | High in a cycle where the core writes the data store |
| dm_addr_o | output | 32 | Byte address of that data write |
| dm_wdata_o | output | 32 | Data of that write |

## Verification
The hardest states to reach are the ones where something must not happen: encodings that sit next to valid ones (a store-like opcode, an unknown func, an add carrying a shift amount), and load-port strobes that arrive after reset has fallen. The stimulus places these words in a program between valid loads. It then reads the registers the stray words would have hit, counts every data write seen on the pins, and finally runs a load that fetches the data word the blocked load-port write aimed at. Branches are reached through equal and unequal register pairs built by loads, ending in a backward branch that holds the PC at a fixed address.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [2:0] {
        CLS_ALU,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_NONE
    } instr_cls_e;

    typedef struct packed {
        logic    dst_rd;
        logic    wr_reg;
        logic    imm_b;
        alu_op_e alu_op;
        logic    mem_wr;
        logic    mem_rd;
        logic    wb_mem;
        logic    is_branch;
    } ctrl_t;

endpackage

// File: rtl/core_ctrl.sv
module core_ctrl
    import core_pkg::*;
(
    input  logic [5:0]  opcode,
    input  logic [4:0]  shamt,
    input  logic [5:0]  func,
    output instr_cls_e  cls,
    output ctrl_t       ctrl
);

    alu_op_e rtype_op;

    // Classify the word; anything not matched stays CLS_NONE.
    always_comb begin
        cls      = CLS_NONE;
        rtype_op = ALU_ADD;
        unique case (opcode)
            OPC_RTYPE: begin
                if (shamt == 5'd0) begin
                    unique case (func)
                        FN_ADD:  begin cls = CLS_ALU; rtype_op = ALU_ADD; end
                        FN_SUB:  begin cls = CLS_ALU; rtype_op = ALU_SUB; end
                        FN_AND:  begin cls = CLS_ALU; rtype_op = ALU_AND; end
                        FN_OR:   begin cls = CLS_ALU; rtype_op = ALU_OR;  end
                        FN_SLT:  begin cls = CLS_ALU; rtype_op = ALU_SLT; end
                        default: cls = CLS_NONE;
                    endcase
                end
            end
            OPC_LOAD:  cls = CLS_LOAD;
            OPC_STORE: cls = CLS_STORE;
            OPC_BEQ:   cls = CLS_BRANCH;
            default:   cls = CLS_NONE;
        endcase
    end

    // Steering and enables per class.
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (cls)
            CLS_ALU: begin
                ctrl.dst_rd = 1'b1;
                ctrl.wr_reg = 1'b1;
                ctrl.alu_op = rtype_op;
            end
            CLS_LOAD: begin
                ctrl.wr_reg = 1'b1;
                ctrl.imm_b  = 1'b1;
                ctrl.mem_rd = 1'b1;
                ctrl.wb_mem = 1'b1;
            end
            CLS_STORE: begin
                ctrl.imm_b  = 1'b1;
                ctrl.mem_wr = 1'b1;
            end
            CLS_BRANCH: begin
                ctrl.alu_op    = ALU_SUB;
                ctrl.is_branch = 1'b1;
            end
            CLS_NONE: begin
                ctrl.alu_op = ALU_ADD;
            end
        endcase
    end

endmodule

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        y = '0;
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    parameter int NRD  = 3,
    parameter int AW   = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NRD-1:0][AW-1:0] ra,
    output logic [NRD-1:0][W-1:0]  rd,
    input  logic                   we,
    input  logic [AW-1:0]          wa,
    input  logic [W-1:0]           wd
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd[g] = (ra[g] == '0) ? '0 : regs[ra[g]];
    end

    // R4/R5: a non-zero destination holds the written value one edge later.
    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));

    // R7: storage for register 0 never leaves zero.
    p_zero_reg_r7: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0);

endmodule

// File: rtl/core_wmem.sv
module core_wmem #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    assign rdata = mem[ra];

endmodule

// File: rtl/sc_core_top.sv
module sc_core_top
    import core_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IA_W = $clog2(IMEM_WORDS),
    localparam int DA_W = $clog2(DMEM_WORDS),
    localparam int LD_W = (IA_W > DA_W) ? IA_W : DA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_en,
    input  logic            load_sel,
    input  logic [LD_W-1:0] load_addr,
    input  logic [31:0]     load_data,
    input  logic [4:0]      dbg_sel,
    output logic [31:0]     dbg_val,
    output logic [31:0]     pc_o,
    output logic            dm_we_o,
    output logic [31:0]     dm_addr_o,
    output logic [31:0]     dm_wdata_o
);

    localparam int NREG   = 32;
    localparam int RAW    = $clog2(NREG);
    localparam int NRD    = 3;
    localparam int IMM_W  = 16;

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target;
    logic [31:0]     instr;
    logic [5:0]      f_op, f_func;
    logic [4:0]      f_rs, f_rt, f_rd, f_shamt;
    logic [IMM_W-1:0] f_imm;
    logic [XLEN-1:0] imm_sx;

    instr_cls_e      cls;
    ctrl_t           ctrl;

    logic [NRD-1:0][RAW-1:0]  rf_ra;
    logic [NRD-1:0][XLEN-1:0] rf_rd;
    logic [XLEN-1:0] rs_val, rt_val;
    logic            rf_we;
    logic [RAW-1:0]  rf_wa;
    logic [XLEN-1:0] rf_wd;

    logic [XLEN-1:0] alu_b, alu_y;
    logic            alu_zero;
    logic            take_br;

    logic            im_we, dm_we;
    logic [DA_W-1:0] dm_wa;
    logic [XLEN-1:0] dm_wd, dm_rdata, dm_rd_data;

    // Instruction store: written only through the load port in reset.
    assign im_we = rst && load_en && !load_sel;

    core_wmem #(.W(32), .DEPTH(IMEM_WORDS)) u_imem (
        .clk   (clk),
        .we    (im_we),
        .wa    (load_addr[IA_W-1:0]),
        .wd    (load_data),
        .ra    (pc_q[IA_W+1:2]),
        .rdata (instr)
    );

    // Field split.
    assign f_op    = instr[31:26];
    assign f_rs    = instr[25:21];
    assign f_rt    = instr[20:16];
    assign f_rd    = instr[15:11];
    assign f_shamt = instr[10:6];
    assign f_func  = instr[5:0];
    assign f_imm   = instr[15:0];
    assign imm_sx  = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};

    core_ctrl u_ctrl (
        .opcode (f_op),
        .shamt  (f_shamt),
        .func   (f_func),
        .cls    (cls),
        .ctrl   (ctrl)
    );

    // Register file: port 0 rs, port 1 rt, port 2 observation.
    assign rf_ra[0] = f_rs;
    assign rf_ra[1] = f_rt;
    assign rf_ra[2] = dbg_sel;
    assign rs_val   = rf_rd[0];
    assign rt_val   = rf_rd[1];
    assign dbg_val  = rf_rd[2];

    assign rf_we = !rst && ctrl.wr_reg;
    assign rf_wa = ctrl.dst_rd ? f_rd : f_rt;
    assign rf_wd = ctrl.wb_mem ? dm_rd_data : alu_y;

    core_regfile #(.W(XLEN), .NREG(NREG), .NRD(NRD)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra  (rf_ra),
        .rd  (rf_rd),
        .we  (rf_we),
        .wa  (rf_wa),
        .wd  (rf_wd)
    );

    // Execute.
    assign alu_b = ctrl.imm_b ? imm_sx : rt_val;

    core_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data store: load port in reset, core writes otherwise.
    assign dm_we = rst ? (load_en && load_sel) : ctrl.mem_wr;
    assign dm_wa = rst ? load_addr[DA_W-1:0] : alu_y[DA_W+1:2];
    assign dm_wd = rst ? load_data : rt_val;

    core_wmem #(.W(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .wa    (dm_wa),
        .wd    (dm_wd),
        .ra    (alu_y[DA_W+1:2]),
        .rdata (dm_rdata)
    );

    assign dm_rd_data = ctrl.mem_rd ? dm_rdata : '0;

    assign dm_we_o    = !rst && ctrl.mem_wr;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

    // Next PC.
    assign pc_plus4  = pc_q + XLEN'(4);
    assign br_target = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
    assign take_br   = ctrl.is_branch && alu_zero;
    assign pc_next   = take_br ? br_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o = pc_q;

    // R2: without a taken branch the PC steps by one word.
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        !take_br |=> (pc_q == $past(pc_q) + XLEN'(4)));

    // R3: equal operands on a branch redirect by the scaled offset.
    p_branch_r3: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_BRANCH && rs_val == rt_val)
        |=> (pc_q == $past(pc_q) + XLEN'(4) + ($past(imm_sx) << 2)));

    // R6: a data write never coincides with a register write.
    p_store_no_reg_r6: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> !rf_we);

    // R8: an unrecognised word touches neither store.
    p_unknown_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_NONE) |-> (!rf_we && !dm_we_o));

endmodule

// File: tb/sc_core_top_tb_top.sv
module sc_core_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 64;

    localparam logic [5:0] OP_R = 6'b000000, OP_LW = 6'b100011,
                           OP_SW = 6'b101011, OP_BEQ = 6'b000100;
    localparam logic [5:0] F_ADD = 6'b100000, F_SUB = 6'b100010,
                           F_AND = 6'b100100, F_OR = 6'b100101,
                           F_SLT = 6'b101010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic        load_sel = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] dbg_val, pc_o, dm_addr_o, dm_wdata_o;
    logic        dm_we_o;

    int checks = 0;
    int fails  = 0;

    logic [31:0] prog [WORDS];
    logic [31:0] dat  [WORDS];

    int          st_count = 0;
    logic [31:0] st_first_addr, st_first_data, st_last_addr, st_last_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .load_sel   (load_sel),
        .load_addr  (load_addr),
        .load_data  (load_data),
        .dbg_sel    (dbg_sel),
        .dbg_val    (dbg_val),
        .pc_o       (pc_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    // Data-write monitor, sampled with pre-edge values.
    always @(posedge clk) begin
        if (!rst && dm_we_o) begin
            if (st_count == 0) begin
                st_first_addr = dm_addr_o;
                st_first_data = dm_wdata_o;
            end
            st_last_addr = dm_addr_o;
            st_last_data = dm_wdata_o;
            st_count++;
        end
    end

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [4:0] rd,
                                          input logic [4:0] sh);
        return {OP_R, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input int r, input logic [31:0] exp);
        dbg_sel = 5'(r);
        #1;
        check(req, dbg_val, exp);
    endtask

    task automatic clear_images();
        for (int i = 0; i < WORDS; i++) begin
            prog[i] = '0;
            dat[i]  = '0;
        end
    endtask

    // Hold reset, write both stores, then release on a falling edge.
    task automatic load_and_release();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            load_en = 1'b1; load_sel = 1'b0; load_addr = 6'(i); load_data = prog[i];
        end
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            load_en = 1'b1; load_sel = 1'b1; load_addr = 6'(i); load_data = dat[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        st_count = 0;
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ALU operations, loads, register 0, PC stepping.
    task automatic test_alu();
        clear_images();
        dat[0] = 32'd7; dat[1] = 32'hFFFF_FFFD; dat[2] = 32'h0F0F_00FF;
        dat[9] = 32'hAAAA_5555;
        prog[0]  = enc_i(OP_LW, 0, 1, 16'd0);
        prog[1]  = enc_i(OP_LW, 0, 2, 16'd4);
        prog[2]  = enc_i(OP_LW, 0, 3, 16'd8);
        prog[3]  = enc_r(F_ADD, 1, 2, 4, 0);
        prog[4]  = enc_r(F_SUB, 1, 2, 5, 0);
        prog[5]  = enc_r(F_AND, 1, 3, 6, 0);
        prog[6]  = enc_r(F_OR,  2, 3, 7, 0);
        prog[7]  = enc_r(F_SLT, 2, 1, 8, 0);
        prog[8]  = enc_r(F_SLT, 1, 2, 9, 0);
        prog[9]  = enc_r(F_ADD, 1, 1, 0, 0);
        prog[10] = enc_r(F_SUB, 2, 1, 10, 0);
        prog[11] = enc_i(OP_LW, 0, 0, 16'd36);
        load_and_release();
        #1;
        check("R1 pc after reset", pc_o, 32'd0);
        chk_reg("R1 r1 after reset", 1, 32'd0);
        chk_reg("R1 r31 after reset", 31, 32'd0);
        run(1);
        check("R2 pc after one step", pc_o, 32'd4);
        chk_reg("R10 r1 right after load", 1, 32'd7);
        run(11);
        check("R2 pc after twelve steps", pc_o, 32'd48);
        chk_reg("R4 add", 4, 32'd4);
        chk_reg("R4 sub", 5, 32'd10);
        chk_reg("R4 and", 6, 32'd7);
        chk_reg("R4 or", 7, 32'hFFFF_FFFF);
        chk_reg("R4 slt signed true", 8, 32'd1);
        chk_reg("R4 slt signed false", 9, 32'd0);
        chk_reg("R4 sub negative", 10, 32'hFFFF_FFF6);
        chk_reg("R5 load sign word", 2, 32'hFFFF_FFFD);
        chk_reg("R7 r0 after writes", 0, 32'd0);
    endtask

    // Stores, loads with negative offset.
    task automatic test_mem();
        clear_images();
        dat[0] = 32'd7; dat[5] = 32'h1234_5678; dat[6] = 32'd24;
        prog[0] = enc_i(OP_LW, 0, 1, 16'd0);
        prog[1] = enc_i(OP_LW, 0, 12, 16'd24);
        prog[2] = enc_i(OP_SW, 0, 1, 16'd16);
        prog[3] = enc_i(OP_LW, 0, 10, 16'd16);
        prog[4] = enc_i(OP_LW, 12, 11, 16'hFFFC);
        prog[5] = enc_i(OP_SW, 12, 11, 16'hFFE8);
        prog[6] = enc_i(OP_LW, 0, 13, 16'd0);
        load_and_release();
        run(7);
        check("R6 store count", 32'(st_count), 32'd2);
        check("R6 first store address", st_first_addr, 32'd16);
        check("R6 first store data", st_first_data, 32'd7);
        check("R6 second store address", st_last_addr, 32'd0);
        chk_reg("R6 store leaves rt", 1, 32'd7);
        chk_reg("R5 load after store", 10, 32'd7);
        chk_reg("R5 negative offset", 11, 32'h1234_5678);
        chk_reg("R6 overwrite read back", 13, 32'h1234_5678);
    endtask

    // Branch taken, not taken, backward self-loop.
    task automatic test_branch();
        clear_images();
        dat[0] = 32'd5;
        prog[0] = enc_i(OP_LW, 0, 1, 16'd0);
        prog[1] = enc_i(OP_LW, 0, 2, 16'd0);
        prog[2] = enc_i(OP_BEQ, 1, 2, 16'd3);
        prog[3] = enc_i(OP_LW, 0, 3, 16'd0);
        prog[4] = enc_i(OP_LW, 0, 4, 16'd0);
        prog[5] = enc_i(OP_LW, 0, 5, 16'd0);
        prog[6] = enc_i(OP_BEQ, 1, 0, 16'd5);
        prog[7] = enc_i(OP_LW, 0, 6, 16'd0);
        prog[8] = enc_i(OP_BEQ, 0, 0, 16'hFFFF);
        load_and_release();
        run(3);
        check("R3 taken forward", pc_o, 32'd24);
        run(1);
        check("R3 not taken", pc_o, 32'd28);
        run(10);
        check("R3 backward self loop", pc_o, 32'd32);
        chk_reg("R3 skipped r3", 3, 32'd0);
        chk_reg("R3 skipped r5", 5, 32'd0);
        chk_reg("R3 fall-through r6", 6, 32'd5);
        check("R3 branch no store", 32'(st_count), 32'd0);
    endtask

    // Unrecognised words, load port blocked while running.
    task automatic test_quiet();
        clear_images();
        dat[0] = 32'd9; dat[3] = 32'h0000_0055;
        prog[0] = enc_i(OP_LW, 0, 1, 16'd0);
        prog[1] = enc_i(6'b111111, 0, 1, 16'd4);
        prog[2] = enc_r(6'b111111, 1, 1, 2, 0);
        prog[3] = enc_r(F_ADD, 1, 1, 3, 5'd3);
        prog[4] = enc_i(6'b101010, 0, 1, 16'd0);
        prog[5] = '0;
        prog[6] = enc_i(OP_LW, 0, 8, 16'd12);
        load_and_release();
        load_en = 1'b1; load_sel = 1'b0; load_addr = 6'd5;
        load_data = enc_i(OP_LW, 0, 7, 16'd0);
        @(negedge clk);
        load_sel = 1'b1; load_addr = 6'd3; load_data = 32'hDEAD_BEEF;
        @(negedge clk);
        load_en = 1'b0;
        run(5);
        check("R8 pc advanced", pc_o, 32'd28);
        chk_reg("R8 unknown opcode keeps rt", 1, 32'd9);
        chk_reg("R8 unknown func", 2, 32'd0);
        chk_reg("R8 nonzero shamt", 3, 32'd0);
        check("R8 no data writes", 32'(st_count), 32'd0);
        chk_reg("R9 instruction load ignored", 7, 32'd0);
        chk_reg("R9 data load ignored", 8, 32'h0000_0055);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        test_alu();
        test_mem();
        test_branch();
        test_quiet();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule